// File: doc/BRIEF.md
# Filled rectangle coordinate generator

This block walks every cell of a solid axis-aligned rectangle on a pixel grid and presents one (x, y) coordinate pair per cycle, marked by a valid strobe. A drawing engine feeding a frame buffer gives it a start corner, a height and a width. It then consumes the stream of coordinates until the block raises done. Writing pixels, display timing and clipping are left to the logic around it.

The sweep is two nested counters. The outer index selects a column offset that is added to y. The inner index runs over the height and is added to x. Requests are accepted with a start/ready handshake that wastes no cycles. The corner and size are captured on the same edge that sees start. Ready may be wired straight back to start so that runs follow each other with no extra glue.

Top module: `rect_fill_gen`

## Requirements
- R1: A clock edge with `rst` high returns the block to idle. From the next cycle on, `ready` is 1 and `valid` and `done` are 0. This also applies when reset arrives in the middle of a run.
- R2: An edge with `start` and `ready` both high captures `start_x`, `start_y`, `height` and `width`. If both sizes are non-zero, `ready` is 0 and `valid` is 0 in the cycle after that edge.
- R3: The pairs come out in consecutive cycles, starting one cycle after capture. For outer index i0 from 0 to width-1, and inside it inner index i1 from 0 to height-1, the pair is `pos_x` = start_x + i1 and `pos_y` = start_y + i0, both taken modulo 2^CW.
- R4: A run produces exactly width × height cycles with `valid` high, and `valid` is 0 in the cycle after the last pair.
- R5: `done` and `ready` rise together in the cycle that carries the last pair and are 0 in every earlier cycle of the run. After that, `done` stays 1 until the next non-empty run is accepted.
- R6: If the captured height or width is zero, no valid pair is produced. In the cycle after capture, `done` is 1 and `ready` is 1.
- R7: While `ready` is 0, `start` is ignored. Changes on `start_x`, `start_y`, `height` and `width` during a run have no effect on the pairs produced.
- R8: While `valid` is 0, `pos_x` and `pos_y` keep their previous values.
- R9: With `start` tied to `ready`, a new run is captured on the first edge after the cycle in which `ready` rose. Its sizes come from the ports at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a run; taken only while ready is high |
| start_x | input | CW | X coordinate of the start corner |
| start_y | input | CW | Y coordinate of the start corner |
| height | input | DW | Number of inner steps (added to x) |
| width | input | DW | Number of outer steps (added to y) |
| ready | output | 1 | Block idle and able to accept start |
| valid | output | 1 | pos_x/pos_y carry a new pair this cycle |
| pos_x | output | CW | Emitted x coordinate |
| pos_y | output | CW | Emitted y coordinate |
| done | output | 1 | Last run has finished |

## Verification
Random corners and sizes up to 6×6 exercise the nested ordering. A model that swapped the roles of the two counters, or added the outer index to x, gives a different sequence as soon as height and width differ. Directed cases cover single-row, single-column and 1×1 rectangles, which stress the inner wrap and the last-pair detection. Zero height and zero width are also covered, to separate an early exit from a hang. A corner near the top of the coordinate range shows whether the sums wrap. Runs with random start pulses and changing ports in the middle show whether captured state is protected. A chain of runs with start tied to ready, including an empty one, checks that each capture happens exactly one edge after ready rises.

// File: rtl/rect_gen_pkg.sv
package rect_gen_pkg;
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/rect_scan_ctr.sv
// Nested index pair: i1 sweeps the height, i0 steps once per i1 wrap.
module rect_scan_ctr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          busy,
  input  logic [DW-1:0] lim_h,
  input  logic [DW-1:0] lim_w,
  output logic [DW-1:0] i0,
  output logic [DW-1:0] i1,
  output logic          last
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic inner_end;

  assign inner_end = (i1 == lim_h - ONE);
  assign last      = inner_end && (i0 == lim_w - ONE);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      i0 <= '0;
      i1 <= '0;
    end else if (step) begin
      if (inner_end) begin
        i1 <= '0;
        i0 <= i0 + ONE;
      end else begin
        i1 <= i1 + ONE;
      end
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (i1 < lim_h) && (i0 < lim_w)); // R3
endmodule

// File: rtl/rect_coord_out.sv
// Output registers: base + offset on emit, hold otherwise.
module rect_coord_out #(
  parameter int CW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          emit,
  input  logic [CW-1:0] base_x,
  input  logic [CW-1:0] base_y,
  input  logic [DW-1:0] off_x,
  input  logic [DW-1:0] off_y,
  output logic [CW-1:0] px,
  output logic [CW-1:0] py,
  output logic          vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      px  <= '0;
      py  <= '0;
    end else begin
      vld <= emit;
      if (emit) begin
        px <= base_x + CW'(off_x);
        py <= base_y + CW'(off_y);
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !emit |=> $stable(px) && $stable(py)); // R8
endmodule

// File: rtl/rect_fill_gen.sv
module rect_fill_gen #(
  parameter int CW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] start_x,
  input  logic [CW-1:0] start_y,
  input  logic [DW-1:0] height,
  input  logic [DW-1:0] width,
  output logic          ready,
  output logic          valid,
  output logic [CW-1:0] pos_x,
  output logic [CW-1:0] pos_y,
  output logic          done
);
  import rect_gen_pkg::*;

  phase_e        phase;
  logic [CW-1:0] cap_x, cap_y;
  logic [DW-1:0] cap_h, cap_w;
  logic [DW-1:0] idx0, idx1;
  logic          accept, empty_in, emit, last_pair;

  assign accept   = start && ready;
  assign empty_in = (height == '0) || (width == '0);
  assign emit     = (phase == PH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      ready <= 1'b1;
      done  <= 1'b0;
      cap_x <= '0;
      cap_y <= '0;
      cap_h <= '0;
      cap_w <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            cap_x <= start_x;
            cap_y <= start_y;
            cap_h <= height;
            cap_w <= width;
            if (empty_in) begin
              done <= 1'b1;
            end else begin
              phase <= PH_RUN;
              ready <= 1'b0;
              done  <= 1'b0;
            end
          end
        end
        PH_RUN: begin
          if (last_pair) begin
            phase <= PH_IDLE;
            ready <= 1'b1;
            done  <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  rect_scan_ctr #(.DW(DW)) u_scan (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .step  (emit),
    .busy  (emit),
    .lim_h (cap_h),
    .lim_w (cap_w),
    .i0    (idx0),
    .i1    (idx1),
    .last  (last_pair)
  );

  rect_coord_out #(.CW(CW), .DW(DW)) u_out (
    .clk    (clk),
    .rst    (rst),
    .emit   (emit),
    .base_x (cap_x),
    .base_y (cap_y),
    .off_x  (idx1),
    .off_y  (idx0),
    .px     (pos_x),
    .py     (pos_y),
    .vld    (valid)
  );

  AST_READY_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ready && !valid && !done); // R1
  AST_BUSY_LOW: assert property (@(posedge clk) disable iff (rst)
    accept && !empty_in |=> !ready && !valid); // R2
  AST_CAP_STABLE: assert property (@(posedge clk) disable iff (rst)
    !ready |=> $stable(cap_x) && $stable(cap_y) && $stable(cap_h) && $stable(cap_w)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> ready); // R5
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (rst)
    valid && ready |-> done); // R5
  AST_EMPTY_RUN: assert property (@(posedge clk) disable iff (rst)
    accept && empty_in |=> done && ready && !valid); // R6
endmodule

// File: tb/rect_fill_gen_bench.sv
module rect_fill_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_drv;
  logic          tie;
  logic          start;
  logic [CW-1:0] start_x, start_y;
  logic [DW-1:0] height, width;
  logic          ready, valid, done;
  logic [CW-1:0] pos_x, pos_y;
  int            total = 0;
  int            bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign start = tie ? ready : start_drv;

  rect_fill_gen #(.CW(CW), .DW(DW)) u_rect_fill_gen (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .start_x (start_x),
    .start_y (start_y),
    .height  (height),
    .width   (width),
    .ready   (ready),
    .valid   (valid),
    .pos_x   (pos_x),
    .pos_y   (pos_y),
    .done    (done)
  );

  function automatic int exp_coord(int base, int off);
    return (base + off) & ((1 << CW) - 1);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_ports(int x, int y, int h, int w);
    start_x = CW'(x);
    start_y = CW'(y);
    height  = DW'(h);
    width   = DW'(w);
  endtask

  // Capture is expected on the next rising edge; returns at the negedge
  // where ready is back high.
  task automatic watch_run(int x, int y, int h, int w, bit noise, string cap_tag);
    int n = h * w;
    int cnt = 0;
    @(negedge clk);
    start_drv = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1, "R6", "done", int'(done), 1);
      chk(ready == 1'b1, "R6", "ready", int'(ready), 1);
      chk(valid == 1'b0, "R6", "valid", int'(valid), 0);
      return;
    end
    chk(ready == 1'b0, cap_tag, "ready after capture", int'(ready), 0);
    chk(valid == 1'b0, "R2", "valid after capture", int'(valid), 0);
    if (noise) begin
      set_ports($urandom, $urandom, $urandom, $urandom); // R7 port churn
      start_drv = 1'($urandom);
    end
    for (int i0 = 0; i0 < w; i0++) begin
      for (int i1 = 0; i1 < h; i1++) begin
        bit is_last;
        @(negedge clk);
        cnt++;
        is_last = (cnt == n);
        chk(valid == 1'b1, "R4", "valid in run", int'(valid), 1);
        chk(int'(pos_x) == exp_coord(x, i1), "R3", "pos_x", int'(pos_x), exp_coord(x, i1));
        chk(int'(pos_y) == exp_coord(y, i0), "R3", "pos_y", int'(pos_y), exp_coord(y, i0));
        chk(done == is_last, "R5", "done", int'(done), int'(is_last));
        chk(ready == is_last, "R5", "ready", int'(ready), int'(is_last));
        start_drv = (noise && !is_last) ? 1'($urandom) : 1'b0; // R7 ignored start
      end
    end
  endtask

  task automatic solo_run(int x, int y, int h, int w, bit noise);
    logic [CW-1:0] hx, hy;
    @(negedge clk);
    set_ports(x, y, h, w);
    start_drv = 1'b1;
    watch_run(x, y, h, w, noise, "R2");
    hx = pos_x;
    hy = pos_y;
    @(negedge clk);
    chk(valid == 1'b0, "R4", "valid after run", int'(valid), 0);
    chk(pos_x == hx, "R8", "pos_x hold", int'(pos_x), int'(hx));
    chk(pos_y == hy, "R8", "pos_y hold", int'(pos_y), int'(hy));
    chk(done == 1'b1, "R5", "done held", int'(done), 1);
    chk(ready == 1'b1, "R5", "ready idle", int'(ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst = 1'b1;
    tie = 1'b0;
    start_drv = 1'b0;
    set_ports(0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk(ready == 1'b1, "R1", "ready in reset", int'(ready), 1);
    chk(valid == 1'b0, "R1", "valid in reset", int'(valid), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst = 1'b0;

    // directed corners
    solo_run(5, 7, 1, 1, 1'b0);
    solo_run(10, 20, 3, 2, 1'b0);
    solo_run(0, 0, 0, 5, 1'b0);     // R6 zero height
    solo_run(3, 3, 4, 0, 1'b0);     // R6 zero width
    solo_run(1022, 1023, 3, 2, 1'b0); // R3 wrap
    solo_run(50, 60, 1, 5, 1'b1);
    solo_run(70, 80, 5, 1, 1'b1);

    // random runs with ignored starts and port churn
    for (int k = 0; k < 40; k++) begin
      solo_run(int'($urandom % 1024), int'($urandom % 1024),
               int'($urandom % 7), int'($urandom % 7), 1'b1);
    end

    // ready tied to start: back-to-back chain, R9
    begin
      int xs[8];
      int ys[8];
      int hs[8];
      int ws[8];
      for (int k = 0; k < 8; k++) begin
        xs[k] = int'($urandom % 1024);
        ys[k] = int'($urandom % 1024);
        hs[k] = 1 + int'($urandom % 5);
        ws[k] = 1 + int'($urandom % 5);
      end
      hs[3] = 0;
      @(negedge clk);
      set_ports(xs[0], ys[0], hs[0], ws[0]);
      tie = 1'b1;
      for (int k = 0; k < 8; k++) begin
        watch_run(xs[k], ys[k], hs[k], ws[k], 1'b0, "R9");
        if (k < 7) set_ports(xs[k+1], ys[k+1], hs[k+1], ws[k+1]);
        else tie = 1'b0;
      end
      @(negedge clk);
      chk(valid == 1'b0, "R9", "valid after chain", int'(valid), 0);
      chk(ready == 1'b1, "R9", "ready after chain", int'(ready), 1);
    end

    // reset in the middle of a run
    @(negedge clk);
    set_ports(100, 100, 4, 4);
    start_drv = 1'b1;
    @(negedge clk);
    start_drv = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(ready == 1'b1, "R1", "ready after mid reset", int'(ready), 1);
    chk(valid == 1'b0, "R1", "valid after mid reset", int'(valid), 0);
    chk(done == 1'b0, "R1", "done after mid reset", int'(done), 0);
    solo_run(9, 9, 2, 3, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule